// File: doc/BRIEF.md
# Processor Register File with Special-Purpose Registers

This block holds the sixteen 16-bit registers of a small microcontroller core. Index 0 is the program counter, index 1 the stack pointer and index 2 the status register. Index 3 has no storage and returns constants. Indices 4 to 15 are general-purpose locations that can hold either data or addresses. Two read ports and one write port serve the datapath. Alongside them, dedicated hooks let the fetch unit advance or branch the program counter, let the stack logic push and pop, and let the ALU load its arithmetic flags.

Read port A carries a 2-bit addressing-mode code. When the addressed register is the status register or the constant register, that code selects one of six frequently used constants. An instruction can then use such a value without spending a fetch on an immediate word. Read port B always behaves as register mode. Both read ports are registered, as in an FPGA LUT-RAM with an output register. Decode, ALU, memory bus and interrupt sequencing stay outside the block.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the registers load as follows. The program counter takes `rst_vector` with bit 0 cleared. The stack pointer and the status register clear to 0x0000. Both read outputs clear to 0x0000.
- R2: `pc_inc` adds 2 to the program counter. `pc_jump` adds twice the sign-extended 10-bit `jump_ofs` (a word offset) and takes priority over `pc_inc`. Bit 0 of the program counter is always 0, including after a write of an odd value to index 0.
- R3: An explicit register write has priority over the dedicated hooks in the same cycle. A write to index 0 beats `pc_inc` and `pc_jump`. A write to index 1 beats `sp_push` and `sp_pop`. A write to index 2 beats `flag_upd`.
- R4: `stack_addr` is a combinational output. With `sp_push` high it shows the stack pointer minus 2, and the stack pointer takes that value at the edge. Otherwise it shows the current stack pointer, and with `sp_pop` high the stack pointer grows by 2 at the edge. Push takes priority over pop.
- R5: Bit 0 of the stack pointer is always 0. A write of an odd value to index 1 stores the value with bit 0 cleared.
- R6: The status register bits are: C at bit 0, Z at bit 1, N at bit 2, interrupt enable at bit 3, CPU-off at bit 4, oscillator-off at bit 5, clock-gate-0 at bit 6, clock-gate-1 at bit 7 and V at bit 8. A write to index 2 keeps bits 8:0 of the data. Bits 15:9 always read 0. `sr_out` shows the register.
- R7: `flag_upd` loads C from `flag_in[0]`, Z from `flag_in[1]`, N from `flag_in[2]` and V from `flag_in[3]`. Bits 3 to 7 of the status register keep their value.
- R8: On port A, the value returned depends on the index and the addressing mode. Index 3 returns 0x0000, 0x0001, 0x0002 or 0xFFFF for modes 0, 1, 2 or 3. Index 2 returns 0x0004 in mode 2 and 0x0008 in mode 3, and the true status register in modes 0 and 1. Port B reads as mode 0.
- R9: Indices 4 to 15 store the written 16-bit value and return it on either read port, whatever the mode.
- R10: Writes to index 3 have no effect. Index 3 still reads its constants afterwards.
- R11: A read address presented in one cycle yields its data on `rda_data`/`rdb_data` after the next clock edge. The data is the register state before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vector | input | 16 | Program counter value loaded at reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 16 | Register write data |
| rda_addr | input | 4 | Port A read index |
| rda_mode | input | 2 | Port A addressing mode (selects constants) |
| rda_data | output | 16 | Port A registered read data |
| rdb_addr | input | 4 | Port B read index |
| rdb_data | output | 16 | Port B registered read data (register mode) |
| pc_inc | input | 1 | Advance program counter by 2 |
| pc_jump | input | 1 | Add branch offset to program counter |
| jump_ofs | input | 10 | Signed branch offset in words |
| pc_out | output | 16 | Current program counter |
| sp_push | input | 1 | Push: decrement stack pointer by 2 |
| sp_pop | input | 1 | Pop: increment stack pointer by 2 |
| stack_addr | output | 16 | Stack memory address for this cycle |
| flag_upd | input | 1 | Load arithmetic flags |
| flag_in | input | 4 | New flags {V, N, Z, C} |
| sr_out | output | 16 | Current status register |

## Verification
A wrong program counter, stack pointer or status register shows at the ports within one edge, because `pc_out`, `stack_addr` and `sr_out` expose those registers directly. A corrupted general-purpose location stays hidden until that index is read. It then appears on a read output one edge after the address is presented. For this reason both read ports sweep addresses every cycle, and all twelve locations are written before random traffic begins. Priority errors between writes and hooks appear only when both fire in the same cycle, so those collisions are driven deliberately as well as at random.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // register indices whose behaviour is hardwired
  localparam int REG_PC    = 0;
  localparam int REG_SP    = 1;
  localparam int REG_SR    = 2;
  localparam int REG_CG    = 3;
  localparam int GPR_FIRST = 4;

  // status register bit positions
  localparam int SR_C      = 0;
  localparam int SR_Z      = 1;
  localparam int SR_N      = 2;
  localparam int SR_GIE    = 3;
  localparam int SR_CPUOFF = 4;
  localparam int SR_OSCOFF = 5;
  localparam int SR_SCG0   = 6;
  localparam int SR_SCG1   = 7;
  localparam int SR_V      = 8;
  localparam int SR_BITS   = 9;

  // positions inside the flag_in vector
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_BITS = 4;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_IDX = 2'd1,
    AM_IND = 2'd2,
    AM_INC = 2'd3
  } amode_e;
endpackage

// File: rtl/rf_pc_unit.sv
module rf_pc_unit #(
  parameter int W     = 16,
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rst_vec,
  input  logic             wr,
  input  logic [W-1:0]     wr_data,
  input  logic             inc,
  input  logic             jump,
  input  logic [OFS_W-1:0] ofs,
  output logic [W-1:0]     pc_q
);
  localparam logic [W-1:0] EVEN_MASK = ~W'(1);
  localparam logic [W-1:0] STEP      = W'(2);

  logic [W-1:0] ofs_bytes;
  assign ofs_bytes = {{(W-OFS_W-1){ofs[OFS_W-1]}}, ofs, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= rst_vec & EVEN_MASK;
    else if (wr)   pc_q <= wr_data & EVEN_MASK;
    else if (jump) pc_q <= pc_q + ofs_bytes;
    else if (inc)  pc_q <= pc_q + STEP;
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (inc && !jump && !wr) |=> pc_q == $past(pc_q) + STEP); // R2
  AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr |=> pc_q == ($past(wr_data) & EVEN_MASK)); // R3
endmodule

// File: rtl/rf_sp_unit.sv
module rf_sp_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] stack_addr
);
  localparam logic [W-1:0] EVEN_MASK = ~W'(1);
  localparam logic [W-1:0] STEP      = W'(2);

  logic [W-1:0] sp_dec;
  assign sp_dec     = sp_q - STEP;
  assign stack_addr = push ? sp_dec : sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (wr)   sp_q <= wr_data & EVEN_MASK;
    else if (push) sp_q <= sp_dec;
    else if (pop)  sp_q <= sp_q + STEP;
  end

  AST_SP_PUSH: assert property (@(posedge clk) disable iff (rst)
    (push && !wr) |=> sp_q == $past(stack_addr)); // R4
  AST_SP_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !wr) |=> sp_q == $past(sp_q) + STEP); // R4
  AST_SP_EVEN: assert property (@(posedge clk) disable iff (rst)
    !sp_q[0]); // R5
endmodule

// File: rtl/rf_sr_unit.sv
module rf_sr_unit
  import rf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [W-1:0]       wr_data,
  input  logic               flag_upd,
  input  logic [FL_BITS-1:0] flag_in,
  output logic [W-1:0]       sr_q
);
  localparam logic [W-1:0] SR_MASK = W'((1 << SR_BITS) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (wr) begin
      sr_q <= wr_data & SR_MASK;
    end else if (flag_upd) begin
      sr_q[SR_C] <= flag_in[FL_C];
      sr_q[SR_Z] <= flag_in[FL_Z];
      sr_q[SR_N] <= flag_in[FL_N];
      sr_q[SR_V] <= flag_in[FL_V];
    end
  end

  AST_SR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    sr_q[W-1:SR_BITS] == '0); // R6
  AST_SR_CTRL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && !wr) |=> sr_q[SR_SCG1:SR_GIE] == $past(sr_q[SR_SCG1:SR_GIE])); // R7
endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
  parameter int W      = 16,
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [W-1:0]      ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [W-1:0]      rb_data
);
  localparam int DEPTH = (1 << ADDR_W) - BASE;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [W-1:0] mem [DEPTH];

  function automatic logic [ADDR_W-1:0] slot(input logic [ADDR_W-1:0] a);
    return (a >= BASE_A) ? a - BASE_A : '0;
  endfunction

  // no reset on the array so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (we && waddr >= BASE_A) mem[slot(waddr)] <= wdata;
  end

  assign ra_data = mem[slot(ra_addr)];
  assign rb_data = mem[slot(rb_addr)];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rst_vector,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rda_addr,
  input  logic [1:0]        rda_mode,
  output logic [DATA_W-1:0] rda_data,
  input  logic [ADDR_W-1:0] rdb_addr,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              pc_inc,
  input  logic              pc_jump,
  input  logic [OFS_W-1:0]  jump_ofs,
  output logic [DATA_W-1:0] pc_out,
  input  logic              sp_push,
  input  logic              sp_pop,
  output logic [DATA_W-1:0] stack_addr,
  input  logic              flag_upd,
  input  logic [3:0]        flag_in,
  output logic [DATA_W-1:0] sr_out
);
  localparam int NPORTS = 2;
  localparam logic [ADDR_W-1:0] A_PC = ADDR_W'(REG_PC);
  localparam logic [ADDR_W-1:0] A_SP = ADDR_W'(REG_SP);
  localparam logic [ADDR_W-1:0] A_SR = ADDR_W'(REG_SR);
  localparam logic [ADDR_W-1:0] A_CG = ADDR_W'(REG_CG);

  logic [DATA_W-1:0] pc_q, sp_q, sr_q;
  logic [DATA_W-1:0] gpr_a, gpr_b;

  rf_pc_unit #(.W(DATA_W), .OFS_W(OFS_W)) u_pc (
    .clk(clk), .rst(rst), .rst_vec(rst_vector),
    .wr(wr_en && wr_addr == A_PC), .wr_data(wr_data),
    .inc(pc_inc), .jump(pc_jump), .ofs(jump_ofs), .pc_q(pc_q)
  );

  rf_sp_unit #(.W(DATA_W)) u_sp (
    .clk(clk), .rst(rst),
    .wr(wr_en && wr_addr == A_SP), .wr_data(wr_data),
    .push(sp_push), .pop(sp_pop), .sp_q(sp_q), .stack_addr(stack_addr)
  );

  rf_sr_unit #(.W(DATA_W)) u_sr (
    .clk(clk), .rst(rst),
    .wr(wr_en && wr_addr == A_SR), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_in(flag_in), .sr_q(sr_q)
  );

  rf_gpr_bank #(.W(DATA_W), .ADDR_W(ADDR_W), .BASE(GPR_FIRST)) u_gpr (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .ra_addr(rda_addr), .ra_data(gpr_a),
    .rb_addr(rdb_addr), .rb_data(gpr_b)
  );

  logic [NPORTS-1:0][ADDR_W-1:0] p_addr;
  logic [NPORTS-1:0][1:0]        p_mode;
  logic [NPORTS-1:0][DATA_W-1:0] p_gpr;
  assign p_addr = {rdb_addr, rda_addr};
  assign p_mode = {2'b00, rda_mode};   // port B is register mode only
  assign p_gpr  = {gpr_b, gpr_a};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [DATA_W-1:0] nxt, q;
    always_comb begin
      case (p_addr[p])
        A_PC: nxt = pc_q;
        A_SP: nxt = sp_q;
        A_SR: begin
          case (p_mode[p])
            AM_IND:  nxt = DATA_W'(4);
            AM_INC:  nxt = DATA_W'(8);
            default: nxt = sr_q;
          endcase
        end
        A_CG: begin
          case (p_mode[p])
            AM_REG:  nxt = '0;
            AM_IDX:  nxt = DATA_W'(1);
            AM_IND:  nxt = DATA_W'(2);
            default: nxt = '1;
          endcase
        end
        default: nxt = p_gpr[p];
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end
  end

  assign rda_data = g_port[0].q;
  assign rdb_data = g_port[1].q;
  assign pc_out   = pc_q;
  assign sr_out   = sr_q;

  AST_CG_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (rda_addr == A_CG && rda_mode == AM_INC) |=> rda_data == '1); // R8
  AST_CG_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (rdb_addr == A_CG) |=> rdb_data == '0); // R10
  AST_READ_OLD_PC: assert property (@(posedge clk) disable iff (rst)
    (rdb_addr == A_PC) |=> rdb_data == $past(pc_out)); // R11
endmodule

// File: tb/cpu_regfile_test.sv
module cpu_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rst_vector = 16'hC001;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  rda_addr = 0;
  logic [1:0]  rda_mode = 0;
  logic [15:0] rda_data;
  logic [3:0]  rdb_addr = 0;
  logic [15:0] rdb_data;
  logic        pc_inc = 0, pc_jump = 0;
  logic [9:0]  jump_ofs = 0;
  logic [15:0] pc_out;
  logic        sp_push = 0, sp_pop = 0;
  logic [15:0] stack_addr;
  logic        flag_upd = 0;
  logic [3:0]  flag_in = 0;
  logic [15:0] sr_out;

  cpu_regfile uut (
    .clk(clk), .rst(rst), .rst_vector(rst_vector),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rda_addr(rda_addr), .rda_mode(rda_mode), .rda_data(rda_data),
    .rdb_addr(rdb_addr), .rdb_data(rdb_data),
    .pc_inc(pc_inc), .pc_jump(pc_jump), .jump_ofs(jump_ofs), .pc_out(pc_out),
    .sp_push(sp_push), .sp_pop(sp_pop), .stack_addr(stack_addr),
    .flag_upd(flag_upd), .flag_in(flag_in), .sr_out(sr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  logic [15:0] m_pc, m_sp, m_sr;
  logic [15:0] m_gpr [16];

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(int a, int mode);
    case (a)
      0: return m_pc;
      1: return m_sp;
      2: return (mode == 2) ? 16'h0004 : (mode == 3) ? 16'h0008 : m_sr;
      3: return (mode == 0) ? 16'h0000 : (mode == 1) ? 16'h0001 :
                (mode == 2) ? 16'h0002 : 16'hFFFF;
      default: return m_gpr[a];
    endcase
  endfunction

  task automatic model_edge();
    int o;
    if (wr_en && wr_addr == 0) m_pc = wr_data & 16'hFFFE;
    else if (pc_jump) begin
      o = int'(jump_ofs);
      if (o >= 512) o -= 1024;
      m_pc = 16'(int'(m_pc) + 2 * o);
    end else if (pc_inc) m_pc = m_pc + 16'd2;
    if (wr_en && wr_addr == 1) m_sp = wr_data & 16'hFFFE;
    else if (sp_push) m_sp = m_sp - 16'd2;
    else if (sp_pop)  m_sp = m_sp + 16'd2;
    if (wr_en && wr_addr == 2) m_sr = wr_data & 16'h01FF;
    else if (flag_upd) begin
      m_sr[0] = flag_in[0]; m_sr[1] = flag_in[1];
      m_sr[2] = flag_in[2]; m_sr[8] = flag_in[3];
    end
    if (wr_en && wr_addr >= 4) m_gpr[wr_addr] = wr_data;
  endtask

  // one clock: check comb output, advance, check registered outputs
  task automatic step(string tag);
    logic [15:0] ea, eb;
    #1;
    chk(tag, "stack_addr", stack_addr, sp_push ? m_sp - 16'd2 : m_sp);
    ea = mread(int'(rda_addr), int'(rda_mode));
    eb = mread(int'(rdb_addr), 0);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "pc_out", pc_out, m_pc);
    chk(tag, "sr_out", sr_out, m_sr);
    chk(tag, "rda_data", rda_data, ea);
    chk(tag, "rdb_data", rdb_data, eb);
  endtask

  task automatic idle();
    wr_en = 0; pc_inc = 0; pc_jump = 0; sp_push = 0; sp_pop = 0; flag_upd = 0;
  endtask

  task automatic wr(int a, logic [15:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_pc = 16'hC000; m_sp = 0; m_sr = 0;
    // R1: reset state, before any edge out of reset
    chk("R1", "pc_out", pc_out, 16'hC000);
    chk("R1", "sr_out", sr_out, 16'h0000);
    chk("R1", "stack_addr", stack_addr, 16'h0000);
    chk("R1", "rda_data", rda_data, 16'h0000);
    chk("R1", "rdb_data", rdb_data, 16'h0000);

    // R9: fill every general-purpose location, read back on both ports
    for (int i = 4; i < 16; i++) begin
      idle(); wr(i, 16'(i * 16'h1111) ^ 16'h5A0F); step("R9");
    end
    for (int i = 4; i < 16; i++) begin
      idle(); rda_addr = 4'(i); rda_mode = 2'(i); rdb_addr = 4'(19 - i); step("R9");
    end

    // R2: advance, jumps forward, backward and at the most negative offset
    idle(); rda_addr = 0; rdb_addr = 0; rda_mode = 0;
    pc_inc = 1; step("R2"); step("R2");
    idle(); pc_jump = 1; jump_ofs = 10'd5; step("R2");
    jump_ofs = 10'h3FD; step("R2");
    jump_ofs = 10'h200; step("R2");
    jump_ofs = 10'h1FF; pc_inc = 1; step("R2");
    idle(); wr(0, 16'h1235); step("R2");
    // R3: write to index 0 beats the jump and advance hooks
    idle(); wr(0, 16'h4443); pc_inc = 1; pc_jump = 1; jump_ofs = 10'd7; step("R3");

    // R5 / R4: stack pointer alignment, push and pop
    idle(); wr(1, 16'h0281); rdb_addr = 1; step("R5");
    idle(); sp_push = 1; step("R4"); step("R4"); step("R4");
    idle(); sp_pop = 1; step("R4"); step("R4");
    idle(); sp_push = 1; sp_pop = 1; step("R4");
    idle(); wr(1, 16'h0300); sp_push = 1; step("R3");
    idle(); wr(1, 16'h0001); sp_pop = 1; step("R5");
    idle(); sp_push = 1; step("R4");

    // R6 / R7: status register masking and flag loads
    idle(); rda_addr = 2; rda_mode = 0; rdb_addr = 2;
    wr(2, 16'hFFFF); step("R6");
    idle(); flag_upd = 1; flag_in = 4'b0000; step("R7");
    flag_in = 4'b1010; step("R7");
    flag_in = 4'b0101; rda_mode = 1; step("R7");
    idle(); wr(2, 16'h00F8); flag_upd = 1; flag_in = 4'b1111; step("R3");
    idle(); step("R6");

    // R8: constants on port A for both generator indices, all modes
    for (int m = 0; m < 4; m++) begin
      idle(); rda_addr = 3; rda_mode = 2'(m); rdb_addr = 3; step("R8");
      idle(); rda_addr = 2; rda_mode = 2'(m); rdb_addr = 2; step("R8");
    end

    // R10: a write to the constant index changes nothing
    idle(); wr(3, 16'h1234); rda_addr = 3; rda_mode = 0; rdb_addr = 3; step("R10");
    idle(); step("R10");
    rda_mode = 3; step("R10");

    // R11: same-edge write and read return the old value, then the new one
    idle(); wr(5, 16'hAAAA); rda_addr = 5; rda_mode = 0; rdb_addr = 5; step("R11");
    idle(); step("R11");
    idle(); wr(0, 16'h2000); rda_addr = 0; step("R11");
    idle(); step("R11");

    // mixed random traffic over all hooks and ports
    for (int k = 0; k < 600; k++) begin
      idle();
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = 4'($urandom);
      wr_data  = 16'($urandom);
      rda_addr = 4'($urandom);
      rda_mode = 2'($urandom);
      rdb_addr = 4'($urandom);
      pc_inc   = 1'($urandom);
      pc_jump  = ($urandom % 4) == 0;
      jump_ofs = 10'($urandom);
      sp_push  = ($urandom % 4) == 0;
      sp_pop   = ($urandom % 4) == 0;
      flag_upd = 1'($urandom);
      flag_in  = 4'($urandom);
      step("R11");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule